// File: doc/BRIEF.md
# Router Deadlock Recovery Controller

This controller sits beside one router and watches every buffer queue of that router, both input and output. Each queue has a stall timer. The timer counts the cycles in which the queue holds flits but sends none out. When a timer reaches the programmed threshold, the queue is treated as a suspected deadlock. What happens next depends on the flit at the front of that queue.

If a packet header is at the front, the controller asks the token ring for the token of the reserved escape channel. Once it holds the token, it steers the whole packet, from header to tail, into that channel. If a body flit is at the front, the packet cannot be moved, so the network is judged congested. In that case the controller emits a back-off token onto the ring. It then raises an injection-disable output that stops the attached tiles from sending for a programmed number of cycles. A back-off token arriving from the ring starts the same back-off locally.

The control path is a three-state machine:
- `ST_IDLE` scans for timeouts.
- `ST_WAIT` holds a chosen victim until the token arrives.
- `ST_REDIR` steers the victim's flits until its tail leaves.

The transitions are:
- IDLE to WAIT on a header-fronted timeout.
- IDLE stays in IDLE on a body-fronted timeout, and back-off is triggered.
- WAIT to REDIR when the token is taken.
- WAIT to IDLE when the victim drains normally or empties.
- REDIR to IDLE when the tail flit leaves.

Top module: `dlr_ctrl`

## Requirements
- R1: A queue times out when it has been non-empty with no flit leaving for `cfg_thresh` consecutive clock edges. The timeout acts in the cycle after the edge on which the count reaches `cfg_thresh`.
- R2: A queue's stall count returns to zero on any edge where the queue pops a flit or is empty. After such an edge, another `cfg_thresh` stalled edges are needed to time out.
- R3: In `ST_IDLE`, a timed-out queue with `q_head_hdr` high becomes the victim, and the controller enters `ST_WAIT`. In that state `victim_vld` is 1 and `victim_q` holds the queue index.
- R4: In `ST_WAIT`, `tok_take` is high in exactly the cycles where `tok_avail` is high. The controller then enters `ST_REDIR`, where `redir_sel` is one-hot on the victim's bit.
- R5: `redir_sel` stays set until an edge where the victim pops with `q_head_tail` high. After that edge the controller is idle and `redir_sel` is 0.
- R6: If the victim pops a flit or empties while in `ST_WAIT`, the controller returns to `ST_IDLE` without taking a token. `victim_vld` is then 0 and `tok_take` stays 0 even when `tok_avail` rises.
- R7: When several queues time out together, the lowest index is chosen. The others remain timed out and are served after the current redirect ends.
- R8: In `ST_IDLE`, a timed-out queue whose front flit is not a header makes `bo_tok_out` high for one cycle. It also clears that queue's stall count and starts a back-off.
- R9: A high `bo_tok_in` while no back-off is active starts a back-off, and `bo_tok_out` is not raised for it.
- R10: A started back-off holds `inject_disable` high for exactly `cfg_backoff` consecutive cycles, beginning the cycle after the trigger.
- R11: Triggers arriving while `inject_disable` is high, whether local, from the ring, or both in one cycle, neither lengthen the window nor raise `bo_tok_out`.
- R12: After reset, `tok_take`, `redir_sel`, `victim_vld`, `bo_tok_out` and `inject_disable` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_thresh | input | TW | Detection threshold in cycles |
| cfg_backoff | input | BW | Back-off length in cycles |
| q_nonempty | input | NQ | Queue holds at least one flit |
| q_pop | input | NQ | A flit leaves the queue this cycle |
| q_head_hdr | input | NQ | Front flit is a packet header |
| q_head_tail | input | NQ | Front flit is a packet tail |
| tok_avail | input | 1 | Escape-channel token present at this router |
| tok_take | output | 1 | Token captured this cycle |
| redir_sel | output | NQ | One-hot steer of a queue into the escape channel |
| victim_q | output | QW | Index of the chosen queue |
| victim_vld | output | 1 | A victim is held (waiting or redirecting) |
| bo_tok_in | input | 1 | Back-off token seen on the ring |
| bo_tok_out | output | 1 | Emit a back-off token on the ring |
| inject_disable | output | 1 | Attached tiles must stop injecting |

## Verification
Two of this block's functions can fall in the same cycle:
- A local body-flit timeout and an incoming ring back-off token. The bench provokes this by raising `bo_tok_in` in exactly the cycle in which a stalled queue's timeout becomes visible. It then expects one emitted token and one disable window of exactly `cfg_backoff` cycles.
- A ring token landing inside a running window. The bench provokes this with two ring tokens three cycles apart and expects a single window of the base length.

Redirect selection under simultaneous timeouts is judged from the order of token-take and steer events recorded by the monitor.

// File: rtl/dlr_pkg.sv
package dlr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_REDIR = 2'd2
    } dlr_state_e;
endpackage

// File: rtl/dlr_stall_timers.sv
module dlr_stall_timers #(
    parameter int NQ = 6,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] thresh,
    input  logic [NQ-1:0] nonempty,
    input  logic [NQ-1:0] pop,
    input  logic [NQ-1:0] clr,
    output logic [NQ-1:0] timed_out
);
    localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

    for (genvar g = 0; g < NQ; g++) begin : g_q
        logic [TW-1:0] cnt;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (!nonempty[g] || pop[g] || clr[g]) begin
                cnt <= '0;
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end

        assign timed_out[g] = nonempty[g] && !pop[g] && (cnt >= thresh);

        // R2: a pop leaves the count at zero
        a_r2_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
            pop[g] |=> cnt == '0);
    end
endmodule

// File: rtl/dlr_prio_pick.sv
module dlr_prio_pick #(
    parameter int NQ = 6,
    parameter int QW = 3
) (
    input  logic [NQ-1:0] req,
    output logic          any,
    output logic [QW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = QW'(i);
            end
        end
    end
endmodule

// File: rtl/dlr_backoff.sv
module dlr_backoff #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] len,
    input  logic          trig_local,
    input  logic          trig_ring,
    output logic          emit,
    output logic          active
);
    logic [BW-1:0] cnt;
    logic          start;

    assign active = (cnt != '0);
    assign start  = (trig_local || trig_ring) && !active;
    assign emit   = trig_local && !active;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= len;
        end else if (active) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R10: a fresh trigger loads the programmed length
    a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_local || trig_ring) && !active |=> cnt == $past(len));
    // R11: a trigger during an active window does not extend it
    a_r11_merge: assert property (@(posedge clk) disable iff (!rst_n)
        active && (trig_local || trig_ring) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/dlr_ctrl.sv
module dlr_ctrl
    import dlr_pkg::*;
#(
    parameter int NQ = 6,
    parameter int TW = 8,
    parameter int BW = 8,
    parameter int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] cfg_thresh,
    input  logic [BW-1:0] cfg_backoff,
    input  logic [NQ-1:0] q_nonempty,
    input  logic [NQ-1:0] q_pop,
    input  logic [NQ-1:0] q_head_hdr,
    input  logic [NQ-1:0] q_head_tail,
    input  logic          tok_avail,
    output logic          tok_take,
    output logic [NQ-1:0] redir_sel,
    output logic [QW-1:0] victim_q,
    output logic          victim_vld,
    input  logic          bo_tok_in,
    output logic          bo_tok_out,
    output logic          inject_disable
);
    dlr_state_e    state_q, state_d;
    logic [QW-1:0] victim_r, victim_d;
    logic [NQ-1:0] timed_out, clr;
    logic          any_to, bo_local;
    logic [QW-1:0] pick;

    dlr_stall_timers #(.NQ(NQ), .TW(TW)) i_timers (
        .clk(clk), .rst_n(rst_n), .thresh(cfg_thresh),
        .nonempty(q_nonempty), .pop(q_pop), .clr(clr),
        .timed_out(timed_out)
    );

    dlr_prio_pick #(.NQ(NQ), .QW(QW)) i_pick (
        .req(timed_out), .any(any_to), .idx(pick)
    );

    dlr_backoff #(.BW(BW)) i_backoff (
        .clk(clk), .rst_n(rst_n), .len(cfg_backoff),
        .trig_local(bo_local), .trig_ring(bo_tok_in),
        .emit(bo_tok_out), .active(inject_disable)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            victim_r <= '0;
        end else begin
            state_q  <= state_d;
            victim_r <= victim_d;
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        victim_d = victim_r;
        unique case (state_q)
            ST_IDLE: begin
                if (any_to && q_head_hdr[pick]) begin
                    state_d  = ST_WAIT;
                    victim_d = pick;
                end
            end
            ST_WAIT: begin
                if (q_pop[victim_r] || !q_nonempty[victim_r]) begin
                    state_d = ST_IDLE;
                end else if (tok_avail) begin
                    state_d = ST_REDIR;
                end
            end
            ST_REDIR: begin
                if (q_pop[victim_r] && q_head_tail[victim_r]) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tok_take   = 1'b0;
        redir_sel  = '0;
        bo_local   = 1'b0;
        clr        = '0;
        victim_vld = 1'b0;
        victim_q   = victim_r;
        unique case (state_q)
            ST_IDLE: begin
                if (any_to && !q_head_hdr[pick]) begin
                    bo_local   = 1'b1;
                    clr[pick]  = 1'b1;
                end
            end
            ST_WAIT: begin
                victim_vld = 1'b1;
                tok_take   = tok_avail && q_nonempty[victim_r] && !q_pop[victim_r];
            end
            ST_REDIR: begin
                victim_vld          = 1'b1;
                redir_sel[victim_r] = 1'b1;
            end
            default: ;
        endcase
    end

    // R4: the token is only taken while waiting with the token present
    a_r4_take_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        tok_take |-> (state_q == ST_WAIT) && tok_avail);
    // R4: at most one queue steered into the escape channel
    a_r4_onehot_steer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(redir_sel));
    // R5: tail flit leaving ends the redirect
    a_r5_tail_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REDIR) && ((q_pop & q_head_tail & redir_sel) != '0)
        |=> state_q == ST_IDLE);
    // R6: normal drain while waiting abandons the victim
    a_r6_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) && q_pop[victim_r] |=> state_q == ST_IDLE);
    // R8: a back-off emission happens only from idle
    a_r8_emit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bo_tok_out |-> state_q == ST_IDLE);
endmodule

// File: tb/test_dlr_ctrl.sv
`timescale 1ns/1ps
module test_dlr_ctrl;
    localparam int NQ = 6;
    localparam int TW = 8;
    localparam int BW = 8;
    localparam int QW = 3;
    localparam int EV_BOFF = 1, EV_WIN = 2, EV_TAKE = 3, EV_REDIR = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] cfg_thresh = 8'd5;
    logic [BW-1:0] cfg_backoff = 8'd8;
    logic [NQ-1:0] q_nonempty = '0, q_pop = '0, q_head_hdr = '0, q_head_tail = '0;
    logic          tok_avail = 1'b0, bo_tok_in = 1'b0;
    logic          tok_take, victim_vld, bo_tok_out, inject_disable;
    logic [NQ-1:0] redir_sel;
    logic [QW-1:0] victim_q;

    int checks = 0;
    int errors = 0;
    int exp_q[$];

    always #2 clk = ~clk;

    dlr_ctrl #(.NQ(NQ), .TW(TW), .BW(BW)) i_dlr_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh), .cfg_backoff(cfg_backoff),
        .q_nonempty(q_nonempty), .q_pop(q_pop), .q_head_hdr(q_head_hdr),
        .q_head_tail(q_head_tail), .tok_avail(tok_avail), .tok_take(tok_take),
        .redir_sel(redir_sel), .victim_q(victim_q), .victim_vld(victim_vld),
        .bo_tok_in(bo_tok_in), .bo_tok_out(bo_tok_out), .inject_disable(inject_disable)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input int val);
        exp_q.push_back(kind * 65536 + val);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // monitor: turn outputs into events and compare against expectations
    int wlen = 0;
    int rcnt = 0;
    int rq = 0;
    task automatic got_ev(input int kind, input int val, input string req);
        int e;
        e = kind * 65536 + val;
        if (exp_q.size() == 0) begin
            chk(1'b0, req, e, 0);
        end else begin
            int x;
            x = exp_q.pop_front();
            chk(x == e, req, e, x);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (bo_tok_out) got_ev(EV_BOFF, 0, "R8/R11 back-off emit");
            if (inject_disable) wlen++;
            else if (wlen > 0) begin
                got_ev(EV_WIN, wlen, "R10/R11 window length");
                wlen = 0;
            end
            if (tok_take) got_ev(EV_TAKE, int'(victim_q), "R4/R7 token take");
            if (redir_sel != '0) begin
                for (int i = 0; i < NQ; i++) if (redir_sel[i]) rq = i;
                if ((redir_sel & q_pop) != '0) rcnt++;
            end else if (rcnt > 0) begin
                got_ev(EV_REDIR, rq * 16 + rcnt, "R5 redirect flits");
                rcnt = 0;
            end
        end
    end

    task automatic do_redirect(input int q, input int n);
        int guard = 0;
        while (redir_sel == '0 && guard < 100) begin
            cyc(1);
            guard++;
        end
        chk(redir_sel == NQ'(1 << q), "R4 steer one-hot", int'(redir_sel), 1 << q);
        for (int k = 1; k <= n; k++) begin
            q_pop[q] = 1'b1;
            q_head_tail[q] = (k == n);
            cyc(1);
        end
        q_pop = '0;
        q_head_tail = '0;
        q_nonempty[q] = 1'b0;
        q_head_hdr[q] = 1'b0;
        chk(redir_sel == '0, "R5 steer released", int'(redir_sel), 0);
    endtask

    initial begin
        cyc(3);
        // R12 reset state
        chk(!tok_take && !victim_vld && redir_sel == '0, "R12 reset ctrl", int'(redir_sel), 0);
        chk(!bo_tok_out && !inject_disable, "R12 reset back-off", int'(inject_disable), 0);
        rst_n = 1'b1;
        cyc(2);

        // R1/R8/R10: body flit at the front of queue 1, threshold 5
        expect_ev(EV_BOFF, 0);
        expect_ev(EV_WIN, 8);
        q_nonempty[1] = 1'b1;
        cyc(4);
        chk(!bo_tok_out, "R1 no timeout before threshold", int'(bo_tok_out), 0);
        cyc(1);
        chk(bo_tok_out, "R1 timeout at threshold", int'(bo_tok_out), 1);
        cyc(1);
        q_nonempty[1] = 1'b0;
        cyc(12);

        // R2: pop and empty restart the stall count
        q_nonempty[1] = 1'b1;
        cyc(4);
        q_pop[1] = 1'b1;
        cyc(1);
        q_pop[1] = 1'b0;
        cyc(4);
        chk(!bo_tok_out, "R2 pop restarts timer", int'(bo_tok_out), 0);
        q_nonempty[1] = 1'b0;
        cyc(1);
        q_nonempty[1] = 1'b1;
        cyc(4);
        chk(!bo_tok_out, "R2 empty restarts timer", int'(bo_tok_out), 0);
        expect_ev(EV_BOFF, 0);
        expect_ev(EV_WIN, 8);
        cyc(1);
        chk(bo_tok_out, "R2 timeout after full stall", int'(bo_tok_out), 1);
        cyc(1);
        q_nonempty[1] = 1'b0;
        cyc(12);

        // R9: ring token, shorter back-off
        cfg_backoff = 8'd3;
        expect_ev(EV_WIN, 3);
        bo_tok_in = 1'b1;
        cyc(1);
        bo_tok_in = 1'b0;
        chk(inject_disable, "R9 ring token starts back-off", int'(inject_disable), 1);
        cyc(6);
        cfg_backoff = 8'd8;

        // R11: second ring token inside the window is merged
        expect_ev(EV_WIN, 8);
        bo_tok_in = 1'b1;
        cyc(1);
        bo_tok_in = 1'b0;
        cyc(3);
        bo_tok_in = 1'b1;
        cyc(1);
        bo_tok_in = 1'b0;
        cyc(10);

        // R11: local timeout and ring token in the same cycle
        expect_ev(EV_BOFF, 0);
        expect_ev(EV_WIN, 8);
        q_nonempty[4] = 1'b1;
        cyc(5);
        bo_tok_in = 1'b1;
        cyc(1);
        bo_tok_in = 1'b0;
        q_nonempty[4] = 1'b0;
        cyc(12);

        // R3/R4/R5: header on queue 2, token arrives late
        q_nonempty[2] = 1'b1;
        q_head_hdr[2] = 1'b1;
        cyc(6);
        chk(victim_vld && victim_q == 3'd2, "R3 victim held", int'(victim_q), 2);
        chk(!tok_take, "R4 no take without token", int'(tok_take), 0);
        cyc(3);
        expect_ev(EV_TAKE, 2);
        expect_ev(EV_REDIR, 2 * 16 + 3);
        tok_avail = 1'b1;
        cyc(1);
        tok_avail = 1'b0;
        do_redirect(2, 3);
        cyc(3);

        // R7: queues 0 and 3 time out together
        expect_ev(EV_TAKE, 0);
        expect_ev(EV_REDIR, 0 * 16 + 2);
        expect_ev(EV_TAKE, 3);
        expect_ev(EV_REDIR, 3 * 16 + 2);
        tok_avail = 1'b1;
        q_nonempty[0] = 1'b1; q_head_hdr[0] = 1'b1;
        q_nonempty[3] = 1'b1; q_head_hdr[3] = 1'b1;
        do_redirect(0, 2);
        do_redirect(3, 2);
        tok_avail = 1'b0;
        cyc(3);

        // R6: victim drains normally while waiting
        q_nonempty[1] = 1'b1;
        q_head_hdr[1] = 1'b1;
        cyc(6);
        chk(victim_vld && victim_q == 3'd1, "R6 waiting on queue 1", int'(victim_q), 1);
        q_pop[1] = 1'b1;
        cyc(1);
        q_pop = '0;
        q_nonempty[1] = 1'b0;
        q_head_hdr[1] = 1'b0;
        tok_avail = 1'b1;
        chk(!victim_vld, "R6 victim dropped", int'(victim_vld), 0);
        chk(!tok_take, "R6 no token taken", int'(tok_take), 0);
        cyc(2);
        chk(!tok_take && redir_sel == '0, "R6 stays idle", int'(redir_sel), 0);
        tok_avail = 1'b0;
        cyc(4);

        chk(exp_q.size() == 0, "R10 all expected events seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule